// File: doc/BRIEF.md
# Graphic LCD Command Interface

This block sits on the device side of a small monochrome graphic LCD. A host talks to it with single-byte requests. Each request carries a register-select bit, a read/write bit and a data byte. Register-select low with write selects the instruction path. Register-select high with write stores a display byte. Register-select low with read returns the status byte. Register-select high with read returns a display byte.

The block holds the display memory, organised as pages of byte-wide columns, together with the page, column and start-line registers. It also keeps the display enable and the column-direction flag, and a reference-voltage level that is loaded by a two-byte instruction. Driving the segments and commons, the analog bias and the scan timing are left to other blocks. Those blocks take the control state from plain output pins.

Requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Every read produces one response on the next cycle. The response is held on `rsp_data` with `rsp_valid` high until the host raises `rsp_ready`. While a response is held, `req_ready` stays low, so at most one read is ever outstanding and nothing is dropped. Writes are always taken when `req_ready` is high.

Top module: `glcd_cmd_if`

## Requirements
- R1: After reset the status byte reads 0x90: bit 7 (busy) and bit 4 (initialising) are set, and bits 6 (column direction), 5 (display on) and 3..0 are clear. This lasts for RST_CYCLES cycles, after which the status byte reads 0x00. In the same state, `disp_on` is 0, `adc_rev` is 0, `start_line` is 0 and `vref_level` is 0x20.
- R2: While busy, instruction writes and display-data writes are accepted but have no effect, and the column does not move. A display-data read while busy returns 0x00.
- R3: A display-data write stores the byte at the current page and column, then advances the column by one. Each page is a separate storage area.
- R4: A display-data read returns the byte at the current page and column, then advances the column by one.
- R5: When the column is COLS-1, a data access leaves it at COLS-1 and leaves the page unchanged. This is the default saturating variant.
- R6: Instruction 0x3E or 0x3F sets the display enable to bit 0. The result appears on `disp_on` and in status bit 5.
- R7: Instruction 0x40 to 0x7F loads the low six bits of the byte into `start_line`, covering lines 0 to 63.
- R8: Instruction 0x81 arms the reference-voltage sequence. If the next accepted write is an instruction from 0x00 to 0x3F, its low six bits load `vref_level`.
- R9: Any other accepted write after 0x81 cancels the armed sequence. This includes a display-data write. An instruction that cancels the sequence is executed normally, and `vref_level` keeps its value.
- R10: Instruction 0xB0 to 0xBF sets the page to bits 2..0. Instruction 0x10 to 0x1F replaces the column's high nibble, and instruction 0x00 to 0x0F replaces its low nibble. A column value above COLS-1 is clamped to COLS-1.
- R11: Instruction 0xA0 or 0xA1 sets the column-direction flag to bit 0. The flag appears on `adc_rev` and in status bit 6.
- R12: Instruction 0xE2 restarts the busy period and returns every register to its R1 value. The display memory keeps its contents.
- R13: While a response is held, `req_ready` is low and `rsp_data` stays unchanged until `rsp_ready` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_rs | input | 1 | 0 = instruction/status, 1 = display data |
| req_rw | input | 1 | 1 = read, 0 = write |
| req_data | input | 8 | Byte written |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 8 | Status or display byte |
| disp_on | output | 1 | Display enable |
| adc_rev | output | 1 | Column-direction flag |
| start_line | output | 6 | First displayed line |
| vref_level | output | 6 | Reference-voltage parameter |
| busy | output | 1 | Initialisation in progress |

## Verification
Some properties are checked by assertions on every cycle. These are: no register changes while busy, the column never leaving its range, the column stepping by exactly one on an access away from the end, the column holding at the end, the parameter byte loading the level, the armed sequence dropping on any other write, and a held response staying stable. Other behaviour can only be shown by the bench's scenarios, because it depends on what is stored and read back. This covers the stored contents coming back at the right page and column, the exact status bytes, the clamping of column values, and display memory surviving the restart instruction while writes made during the busy period are lost.

// File: rtl/glcd_pkg.sv
package glcd_pkg;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_DISP,
    OP_LINE,
    OP_PAGE,
    OP_COLHI,
    OP_COLLO,
    OP_ADC,
    OP_VMODE,
    OP_VPARAM,
    OP_SRESET
  } op_e;

  typedef struct packed {
    op_e        op;
    logic [5:0] arg;
  } instr_t;

  typedef enum logic [1:0] {
    SRC_STATUS,
    SRC_RAM,
    SRC_ZERO
  } rsp_src_e;

  localparam logic [7:0] CODE_VMODE  = 8'h81;
  localparam logic [7:0] CODE_SRESET = 8'hE2;
  localparam logic [5:0] VREF_RESET  = 6'h20;

endpackage

// File: rtl/glcd_decode.sv
module glcd_decode
  import glcd_pkg::*;
(
  input  logic [7:0] code,
  input  logic       vpend,
  output instr_t     ins
);

  always_comb begin
    ins.arg = code[5:0];
    ins.op  = OP_NONE;
    if (vpend && code[7:6] == 2'b00)          ins.op = OP_VPARAM;
    else if (code[7:4] == 4'h0)               ins.op = OP_COLLO;
    else if (code[7:4] == 4'h1)               ins.op = OP_COLHI;
    else if (code[7:1] == 7'b0011111)         ins.op = OP_DISP;
    else if (code[7:6] == 2'b01)              ins.op = OP_LINE;
    else if (code[7:4] == 4'hB)               ins.op = OP_PAGE;
    else if (code[7:1] == 7'b1010000)         ins.op = OP_ADC;
    else if (code == CODE_VMODE)              ins.op = OP_VMODE;
    else if (code == CODE_SRESET)             ins.op = OP_SRESET;
  end

endmodule

// File: rtl/glcd_ctrl.sv
module glcd_ctrl
  import glcd_pkg::*;
#(
  parameter int PAGES      = 8,
  parameter int COLS       = 132,
  parameter int RST_CYCLES = 16,
  parameter bit WRAP_COL   = 1'b0,
  localparam int PG_W      = $clog2(PAGES),
  localparam int COL_W     = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  instr_t           ins,
  input  logic             data_step,
  output logic             busy,
  output logic             vpend,
  output logic [PG_W-1:0]  page,
  output logic [COL_W-1:0] col,
  output logic             disp_on,
  output logic             adc_rev,
  output logic [5:0]       start_line,
  output logic [5:0]       vref_level
);

  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

  logic [CNT_W-1:0] cnt;
  logic [COL_W-1:0] col_adv;
  logic [7:0]       col8, cand;
  logic [COL_W-1:0] col_set;

  assign busy = (cnt != '0);
  assign col8 = 8'(col);

  generate
    if (WRAP_COL) begin : g_wrap
      assign col_adv = (col == COL_LAST) ? '0 : col + 1'b1;
    end else begin : g_sat
      assign col_adv = (col == COL_LAST) ? col : col + 1'b1;
    end
  endgenerate

  always_comb begin
    cand = (ins.op == OP_COLHI) ? {ins.arg[3:0], col8[3:0]} : {col8[7:4], ins.arg[3:0]};
    col_set = (int'(cand) > COLS - 1) ? COL_LAST : COL_W'(cand);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= CNT_W'(RST_CYCLES);
      vpend      <= 1'b0;
      page       <= '0;
      col        <= '0;
      disp_on    <= 1'b0;
      adc_rev    <= 1'b0;
      start_line <= '0;
      vref_level <= VREF_RESET;
    end else begin
      if (busy) cnt <= cnt - 1'b1;
      if (!busy) begin
        if (cmd_we) begin
          vpend <= (ins.op == OP_VMODE);
          case (ins.op)
            OP_DISP:   disp_on    <= ins.arg[0];
            OP_LINE:   start_line <= ins.arg;
            OP_PAGE:   page       <= PG_W'(ins.arg[2:0]);
            OP_COLHI,
            OP_COLLO:  col        <= col_set;
            OP_ADC:    adc_rev    <= ins.arg[0];
            OP_VPARAM: vref_level <= ins.arg;
            OP_SRESET: begin
              cnt        <= CNT_W'(RST_CYCLES);
              page       <= '0;
              col        <= '0;
              disp_on    <= 1'b0;
              adc_rev    <= 1'b0;
              start_line <= '0;
              vref_level <= VREF_RESET;
            end
            default: ;
          endcase
        end else if (data_step) begin
          vpend <= 1'b0;
          col   <= col_adv;
        end
      end
    end
  end

  // R2: nothing moves while initialising
  p_quiet_while_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(disp_on) && $stable(start_line) && $stable(page)
             && $stable(col) && $stable(adc_rev) && $stable(vref_level));

  // R5: column stays inside the page
  p_col_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(col) <= COLS - 1);

  // R3/R4: one step per access away from the end
  p_col_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_step && !cmd_we && !busy && col != COL_LAST) |=> col == $past(col) + 1'b1);

  generate
    if (!WRAP_COL) begin : g_sat_chk
      // R5: saturate at the last column, page untouched
      p_col_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_step && !cmd_we && !busy && col == COL_LAST) |=> col == COL_LAST && $stable(page));
    end
  endgenerate

  // R8: parameter byte loads the level
  p_vparam_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !busy && ins.op == OP_VPARAM) |=> vref_level == $past(ins.arg));

  // R9: armed sequence dropped by any other write
  p_pend_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (cmd_we || data_step) && !(cmd_we && ins.op == OP_VMODE)) |=> !vpend);

endmodule

// File: rtl/glcd_dram.sv
module glcd_dram #(
  parameter int PAGES  = 8,
  parameter int COLS   = 132,
  localparam int PG_W  = $clog2(PAGES),
  localparam int COL_W = $clog2(COLS),
  localparam int DEPTH = PAGES * COLS,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic             re,
  input  logic [PG_W-1:0]  page,
  input  logic [COL_W-1:0] col,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] addr;

  assign addr = AW'(page) * AW'(COLS) + AW'(col);

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end

endmodule

// File: rtl/glcd_cmd_if.sv
module glcd_cmd_if
  import glcd_pkg::*;
#(
  parameter int PAGES      = 8,
  parameter int COLS       = 132,
  parameter int RST_CYCLES = 16,
  parameter bit WRAP_COL   = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_rs,
  input  logic       req_rw,
  input  logic [7:0] req_data,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [7:0] rsp_data,
  output logic       disp_on,
  output logic       adc_rev,
  output logic [5:0] start_line,
  output logic [5:0] vref_level,
  output logic       busy
);

  localparam int PG_W  = $clog2(PAGES);
  localparam int COL_W = $clog2(COLS);

  logic             accept, cmd_we, data_wr, data_rd, vpend;
  logic [PG_W-1:0]  page;
  logic [COL_W-1:0] col;
  logic [7:0]       ram_q, status_q;
  rsp_src_e         src_q;
  instr_t           ins;

  assign req_ready = !rsp_valid;
  assign accept    = req_valid && req_ready;
  assign cmd_we    = accept && !req_rs && !req_rw;
  assign data_wr   = accept &&  req_rs && !req_rw;
  assign data_rd   = accept &&  req_rs &&  req_rw;

  glcd_decode u_dec (
    .code  (req_data),
    .vpend (vpend),
    .ins   (ins)
  );

  glcd_ctrl #(
    .PAGES      (PAGES),
    .COLS       (COLS),
    .RST_CYCLES (RST_CYCLES),
    .WRAP_COL   (WRAP_COL)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_we     (cmd_we),
    .ins        (ins),
    .data_step  (data_wr || data_rd),
    .busy       (busy),
    .vpend      (vpend),
    .page       (page),
    .col        (col),
    .disp_on    (disp_on),
    .adc_rev    (adc_rev),
    .start_line (start_line),
    .vref_level (vref_level)
  );

  glcd_dram #(
    .PAGES (PAGES),
    .COLS  (COLS)
  ) u_ram (
    .clk   (clk),
    .we    (data_wr && !busy),
    .re    (data_rd && !busy),
    .page  (page),
    .col   (col),
    .wdata (req_data),
    .rdata (ram_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      src_q     <= SRC_STATUS;
      status_q  <= '0;
    end else if (accept && req_rw) begin
      rsp_valid <= 1'b1;
      src_q     <= !req_rs ? SRC_STATUS : (busy ? SRC_ZERO : SRC_RAM);
      status_q  <= {busy, adc_rev, disp_on, busy, 4'b0000};
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_comb begin
    case (src_q)
      SRC_RAM:  rsp_data = ram_q;
      SRC_ZERO: rsp_data = 8'h00;
      default:  rsp_data = status_q;
    endcase
  end

  // R13: held response is stable
  p_rsp_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_data));

endmodule

// File: tb/glcd_cmd_if_test.sv
module glcd_cmd_if_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_rs = 1'b0, req_rw = 1'b0, rsp_ready = 1'b1;
  logic [7:0] req_data = 8'h00;
  logic       req_ready, rsp_valid, disp_on, adc_rev, busy;
  logic [7:0] rsp_data;
  logic [5:0] start_line, vref_level;
  int         n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  glcd_cmd_if uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_rs(req_rs), .req_rw(req_rw), .req_data(req_data), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .disp_on(disp_on), .adc_rev(adc_rev),
    .start_line(start_line), .vref_level(vref_level), .busy(busy)
  );

  // {req[3:0], rs, rw, data[7:0], chk, exp[7:0]}
  localparam int NV = 24;
  localparam logic [22:0] VEC [NV] = '{
    {4'd10, 1'b0, 1'b0, 8'hB2, 1'b0, 8'h00},  // R10 page 2
    {4'd10, 1'b0, 1'b0, 8'h10, 1'b0, 8'h00},
    {4'd10, 1'b0, 1'b0, 8'h05, 1'b0, 8'h00},  // column 5
    {4'd3,  1'b1, 1'b0, 8'h11, 1'b0, 8'h00},  // R3 writes
    {4'd3,  1'b1, 1'b0, 8'h22, 1'b0, 8'h00},
    {4'd3,  1'b1, 1'b0, 8'h33, 1'b0, 8'h00},
    {4'd10, 1'b0, 1'b0, 8'h05, 1'b0, 8'h00},
    {4'd3,  1'b1, 1'b1, 8'h00, 1'b1, 8'h11},  // R3 / R4 reads
    {4'd4,  1'b1, 1'b1, 8'h00, 1'b1, 8'h22},
    {4'd4,  1'b1, 1'b1, 8'h00, 1'b1, 8'h33},
    {4'd10, 1'b0, 1'b0, 8'hB3, 1'b0, 8'h00},
    {4'd10, 1'b0, 1'b0, 8'h05, 1'b0, 8'h00},
    {4'd3,  1'b1, 1'b0, 8'h77, 1'b0, 8'h00},
    {4'd10, 1'b0, 1'b0, 8'hB2, 1'b0, 8'h00},
    {4'd10, 1'b0, 1'b0, 8'h05, 1'b0, 8'h00},
    {4'd3,  1'b1, 1'b1, 8'h00, 1'b1, 8'h11},  // R3 page separation
    {4'd6,  1'b0, 1'b0, 8'h3F, 1'b0, 8'h00},  // R6 on
    {4'd6,  1'b0, 1'b1, 8'h00, 1'b1, 8'h20},
    {4'd11, 1'b0, 1'b0, 8'hA1, 1'b0, 8'h00},  // R11
    {4'd11, 1'b0, 1'b1, 8'h00, 1'b1, 8'h60},
    {4'd6,  1'b0, 1'b0, 8'h3E, 1'b0, 8'h00},
    {4'd6,  1'b0, 1'b1, 8'h00, 1'b1, 8'h40},
    {4'd11, 1'b0, 1'b0, 8'hA0, 1'b0, 8'h00},
    {4'd11, 1'b0, 1'b1, 8'h00, 1'b1, 8'h00}
  };

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic rs, input logic rw, input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    req_valid = 1'b1; req_rs = rs; req_rw = rw; req_data = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    q = rsp_data;
  endtask

  task automatic wr_cmd(input logic [7:0] d);
    logic [7:0] q;
    xfer(1'b0, 1'b0, d, q);
  endtask

  task automatic wr_dat(input logic [7:0] d);
    logic [7:0] q;
    xfer(1'b1, 1'b0, d, q);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] q, h;
    repeat (3) @(negedge clk);
    // R1 reset values
    check(disp_on == 1'b0 && adc_rev == 1'b0, "R1 flags", {6'd0, disp_on, adc_rev}, 8'h00);
    check(start_line == 6'd0, "R1 start_line", 8'(start_line), 8'h00);
    check(vref_level == 6'h20, "R1 vref", 8'(vref_level), 8'h20);
    rst_n = 1'b1;
    xfer(1'b0, 1'b1, 8'h00, q);
    check(q == 8'h90, "R1 status busy", q, 8'h90);
    repeat (20) @(negedge clk);
    xfer(1'b0, 1'b1, 8'h00, q);
    check(q == 8'h00, "R1 status ready", q, 8'h00);

    for (int i = 0; i < NV; i++) begin
      xfer(VEC[i][18], VEC[i][17], VEC[i][16:9], q);
      if (VEC[i][8])
        check(q == VEC[i][7:0], $sformatf("R%0d vector %0d", VEC[i][22:19], i), q, VEC[i][7:0]);
    end

    // R5 saturation and R10 clamp
    wr_cmd(8'hB1); wr_cmd(8'h18); wr_cmd(8'h03);
    wr_dat(8'hAA); wr_dat(8'hBB);
    wr_cmd(8'h03);
    xfer(1'b1, 1'b1, 8'h00, q);
    check(q == 8'hBB, "R5 saturate write", q, 8'hBB);
    xfer(1'b1, 1'b1, 8'h00, q);
    check(q == 8'hBB, "R5 saturate read", q, 8'hBB);
    wr_cmd(8'h1F);
    xfer(1'b1, 1'b1, 8'h00, q);
    check(q == 8'hBB, "R10 column clamp", q, 8'hBB);

    // R7 start line
    wr_cmd(8'h45);
    check(start_line == 6'd5, "R7 line 5", 8'(start_line), 8'h05);
    wr_cmd(8'h7F);
    check(start_line == 6'd63, "R7 line 63", 8'(start_line), 8'h3F);

    // R8 two-byte level
    wr_cmd(8'h81); wr_cmd(8'h2A);
    check(vref_level == 6'h2A, "R8 level", 8'(vref_level), 8'h2A);

    // R9 cancellation by instruction and by data write
    wr_cmd(8'h81); wr_cmd(8'hA1);
    check(adc_rev == 1'b1, "R9 cancel executes", 8'(adc_rev), 8'h01);
    wr_cmd(8'h15);
    check(vref_level == 6'h2A, "R9 level kept", 8'(vref_level), 8'h2A);
    wr_cmd(8'h81); wr_dat(8'h00); wr_cmd(8'h3C);
    check(vref_level == 6'h2A, "R9 data cancels", 8'(vref_level), 8'h2A);
    wr_cmd(8'h81); wr_cmd(8'h3F);
    check(vref_level == 6'h3F && disp_on == 1'b0, "R8 param not on/off", {disp_on, 1'b0, vref_level}, 8'h3F);

    // R13 back-pressure
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_rs = 1'b0; req_rw = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    h = rsp_data;
    repeat (3) @(negedge clk);
    check(rsp_valid && !req_ready && rsp_data == h, "R13 hold", rsp_data, h);
    rsp_ready = 1'b1;
    @(negedge clk);
    check(!rsp_valid && req_ready, "R13 release", {6'd0, rsp_valid, req_ready}, 8'h01);

    // R12 soft restart, R2 ignored while busy
    wr_cmd(8'hB0); wr_cmd(8'h10); wr_cmd(8'h00);
    wr_dat(8'h5A);
    wr_cmd(8'h3F);
    wr_cmd(8'hE2);
    xfer(1'b0, 1'b1, 8'h00, q);
    check(q == 8'h90, "R12 status after restart", q, 8'h90);
    check(vref_level == 6'h20 && adc_rev == 1'b0, "R12 defaults", 8'(vref_level), 8'h20);
    wr_cmd(8'h3F);
    check(disp_on == 1'b0, "R2 cmd ignored", 8'(disp_on), 8'h00);
    wr_dat(8'h99);
    xfer(1'b1, 1'b1, 8'h00, q);
    check(q == 8'h00, "R2 read while busy", q, 8'h00);
    repeat (20) @(negedge clk);
    xfer(1'b0, 1'b1, 8'h00, q);
    check(q == 8'h00, "R12 ready again", q, 8'h00);
    xfer(1'b1, 1'b1, 8'h00, q);
    check(q == 8'h5A, "R12 RAM kept / R2 write ignored", q, 8'h5A);

    summary();
    $finish;
  end

endmodule